// File: doc/BRIEF.md
# Crest and Trough Tracker with Hysteresis

This block follows a stream of sampled amplifier-output codes from one read track and finds the extremes of the waveform. It keeps a single mode flag. While the flag is high, the block hunts for a trough by holding the running minimum of the samples. While the flag is low, it hunts for a crest by holding the running maximum. A peak counts as confirmed when a later sample moves away from the held extreme by at least a programmable step. The block then raises a one-cycle pulse for that peak.

Changing between hunting modes needs two things: a slope reversal in the current mode, and a sample that lies beyond the reference level by a programmable margin. The margin is typically set to the code equivalent of about 100 mV. Short spikes that stay inside the band around the reference therefore cannot produce false peaks. When the mode changes, the held extreme is restarted from the sample that caused the change.

Top module: `crest_trough_tracker`

## Requirements
- R1: During and after reset, `trough_mode` is 1, both pulse outputs are 0, and the held value starts at the all-ones code. Because of that start value, no first sample can confirm a trough.
- R2: In trough mode, a valid sample that is at least `rev_step` above the running minimum sets `trough_pk` to 1 for exactly one cycle, in the cycle after that sample.
- R3: A sample that rises above the held minimum (or falls below the held maximum) by less than `rev_step` produces no pulse.
- R4: Each mode produces at most one peak pulse. A new minimum after a confirmed trough updates the held value but produces no further pulse until the mode has changed.
- R5: Trough mode changes to crest mode (`trough_mode` goes to 0 in the cycle after the sample) only when a trough has been confirmed by that sample or an earlier one, and the sample is strictly greater than `ref_lvl + margin`. A sample exactly equal to that sum does not change the mode.
- R6: In crest mode, a valid sample that is at least `rev_step` below the running maximum sets `crest_pk` to 1 for exactly one cycle, in the cycle after that sample.
- R7: Crest mode returns to trough mode only when a crest has been confirmed and the sample is strictly less than `ref_lvl - margin`. A dip that stays at or above that level keeps crest mode.
- R8: When `smp_vld` is 0, the sample is ignored. The mode, the held extreme and the confirmation state do not change, and no pulse is produced.
- R9: `crest_pk` and `trough_pk` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | W | Unsigned sample code |
| ref_lvl | input | W | Reference level code |
| margin | input | W | Hysteresis margin around the reference |
| rev_step | input | W | Minimum move away from the held extreme that confirms a peak |
| trough_mode | output | 1 | 1 = hunting a trough, 0 = hunting a crest |
| crest_pk | output | 1 | One-cycle crest confirmation pulse |
| trough_pk | output | 1 | One-cycle trough confirmation pulse |

## Verification
Every result is registered once. A pulse or a mode change caused by a sample presented at a clock edge can be seen during the following cycle, and the pulse is gone one cycle later.

The bench drives each sample on a falling edge with the strobe high. It drops the strobe at the next falling edge and reads all three outputs at that same point. This is halfway through the cycle in which the result is due.

Stretches with the strobe low are checked the same way, after each idle cycle. The checks use chosen boundary samples: exactly the step away from the held extreme, and exactly at the reference plus or minus the margin.

// File: rtl/crest_trough_tracker.sv
module crest_trough_tracker #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] ref_lvl,
  input  logic [W-1:0] margin,
  input  logic [W-1:0] rev_step,
  output logic         trough_mode,
  output logic         crest_pk,
  output logic         trough_pk
);
  localparam int E = W + 1;

  logic [W-1:0] held;
  logic         fired;

  wire [E-1:0] s_x   = {1'b0, smp};
  wire [E-1:0] h_x   = {1'b0, held};
  wire [E-1:0] st_x  = {1'b0, rev_step};
  wire [E-1:0] hi_th = {1'b0, ref_lvl} + {1'b0, margin};

  wire below_lo = (s_x + {1'b0, margin}) < {1'b0, ref_lvl};
  wire above_hi = s_x > hi_th;
  wire t_rev    = !fired && (s_x >= h_x + st_x);
  wire c_rev    = !fired && (s_x + st_x <= h_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trough_mode <= 1'b1;
      held        <= '1;
      fired       <= 1'b0;
      crest_pk    <= 1'b0;
      trough_pk   <= 1'b0;
    end else begin
      crest_pk  <= 1'b0;
      trough_pk <= 1'b0;
      if (smp_vld) begin
        if (trough_mode) begin
          if (smp < held) held <= smp;
          if (t_rev) begin
            trough_pk <= 1'b1;
            fired     <= 1'b1;
          end
          if ((t_rev || fired) && above_hi) begin
            trough_mode <= 1'b0;
            held        <= smp;
            fired       <= 1'b0;
          end
        end else begin
          if (smp > held) held <= smp;
          if (c_rev) begin
            crest_pk <= 1'b1;
            fired    <= 1'b1;
          end
          if ((c_rev || fired) && below_lo) begin
            trough_mode <= 1'b1;
            held        <= smp;
            fired       <= 1'b0;
          end
        end
      end
    end
  end

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest_pk && trough_pk));

  // R4
  trough_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trough_pk |=> !trough_pk);

  // R4
  crest_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crest_pk |=> !crest_pk);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(trough_mode) && !crest_pk && !trough_pk);

  // R5
  crest_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trough_mode && !$past(!rst_n) |=> trough_mode || ({1'b0, $past(smp)} > ({1'b0, $past(ref_lvl)} + {1'b0, $past(margin)})));

  // R2
  trough_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trough_mode && !trough_pk |=> !trough_pk);
endmodule

// File: tb/test_crest_trough_tracker.sv
module test_crest_trough_tracker;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [W-1:0] smp = '0;
  logic [W-1:0] ref_lvl = 10'd512;
  logic [W-1:0] margin = 10'd40;
  logic [W-1:0] rev_step = 10'd4;
  logic trough_mode, crest_pk, trough_pk;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crest_trough_tracker #(.W(W)) i_crest_trough_tracker (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .ref_lvl(ref_lvl), .margin(margin), .rev_step(rev_step),
    .trough_mode(trough_mode), .crest_pk(crest_pk), .trough_pk(trough_pk)
  );

  task automatic chk(input logic em, input logic ec, input logic et, input string tag);
    n_chk++;
    if ({trough_mode, crest_pk, trough_pk} !== {em, ec, et}) begin
      n_bad++;
      $display("FAIL %s: got mode/crest/trough=%b%b%b expected %b%b%b",
               tag, trough_mode, crest_pk, trough_pk, em, ec, et);
    end
  endtask

  task automatic send(input int v);
    @(negedge clk);
    smp = v[W-1:0];
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset();
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, "R1 after reset");
    send(1023);
    chk(1'b1, 1'b0, 1'b0, "R1 first sample at max code");
    send(1000);
    chk(1'b1, 1'b0, 1'b0, "R1 no trough against start value");
  endtask

  task automatic t_trough;
    do_reset();
    send(600); send(500); send(400); send(300);
    chk(1'b1, 1'b0, 1'b0, "R2 falling run no pulse");
    send(302);
    chk(1'b1, 1'b0, 1'b0, "R3 rise below step");
    send(304);
    chk(1'b1, 1'b0, 1'b1, "R2 trough confirmed");
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, "R2 pulse one cycle");
    send(306);
    chk(1'b1, 1'b0, 0, "R4 no second trough");
    send(200);
    send(300);
    chk(1'b1, 1'b0, 1'b0, "R4 new min no pulse");
    send(552);
    chk(1'b1, 1'b0, 1'b0, "R5 equal threshold keeps mode");
    send(553);
    chk(1'b0, 1'b0, 1'b0, "R5 switch to crest");
  endtask

  task automatic t_crest;
    send(600); send(700);
    chk(1'b0, 1'b0, 1'b0, "R6 rising run no pulse");
    send(697);
    chk(1'b0, 1'b0, 1'b0, "R3 dip below step");
    send(696);
    chk(1'b0, 1'b1, 1'b0, "R6 crest confirmed");
    @(negedge clk);
    chk(1'b0, 1'b0, 1'b0, "R6 pulse one cycle");
    send(520);
    chk(1'b0, 1'b0, 1'b0, "R7 spike in band keeps crest");
    send(472);
    chk(1'b0, 1'b0, 1'b0, "R7 equal threshold keeps crest");
    send(471);
    chk(1'b1, 1'b0, 1'b0, "R7 return to trough");
  endtask

  task automatic t_idle;
    @(negedge clk);
    smp = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(1'b1, 1'b0, 1'b0, "R8 idle no change");
    end
    send(473);
    chk(1'b1, 1'b0, 1'b0, "R8 held min kept over idle");
    send(475);
    chk(1'b1, 1'b0, 1'b1, "R8 R4 trough in new mode");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_trough();
        t_crest();
        t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule